// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Front End

This block is the serial front end of a small byte-wide non-volatile memory, modelled for synthesis. It sits on a four-wire SPI bus plus a pause input, oversamples all bus pins with the system clock, and decodes an 8-bit instruction. It then gathers an address byte and data bytes, or streams read data and status back on a tri-stated serial output. The storage is 512 bytes. Writes first fill a 16-byte page buffer. When the host deselects the part cleanly, a self-timed commit copies the buffered bytes into a behavioural array that block RAM can implement.

The host must send a write-enable instruction before any array or status write. The enable latch is cleared when a write commits. Two block-protect bits can lock the top quarter, the top half or all of the array. While a commit is in progress only the status read is answered. The host polls it until the busy flag drops.

The bus pins are asynchronous to the system clock. The serial clock must stay at least four system clocks in each phase so that the oversampling front end sees every edge.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset, SO is not driven (`spi_so_oe`=0) and a status read returns 0x00. Status layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect field, bits 7:4 zero.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it. Each takes effect only when chip select rises right after the eighth instruction bit. Any further clock bit cancels it.
- R3: Read is 0000_A011, where A is address bit 8, followed by the low address byte. Data comes out MSB first. SO changes after a falling SCK edge and is valid at the next rising edge. This works in SPI mode 0 and in SPI mode 3.
- R4: During a read the address advances after every byte and wraps from 0x1FF to 0x000.
- R5: Write is 0000_A010 plus the low address byte, then data bytes. The low four address bits wrap inside the 16-byte page. Page bytes that were not sent keep their old contents.
- R6: A write commits only if chip select rises on a byte boundary after at least one data byte, with the write-enable latch set. Otherwise nothing is written and the latch keeps its value.
- R7: A commit keeps status bit 0 set for WRITE_CYCLES system clocks. Meanwhile every instruction except status read (0x05) is ignored, and a read leaves SO undriven.
- R8: A committed write clears the write-enable latch.
- R9: Status write (0x01, one data byte) copies data bits 3:2 into the protect field and clears the latch, but only when the latch is set. Protect 01 locks 0x180-0x1FF, 10 locks 0x100-0x1FF and 11 locks everything. A write to a locked page is discarded.
- R10: While HOLD is low, SCK and SI are ignored and SO is undriven. When HOLD is released the transfer continues from the bit where it stopped.
- R11: SO is undriven while the instruction is shifted in and whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the SO pad driver |

## Verification
A wrong bit counter or state shows up within one byte time as a shifted or wrong read byte, or as SO being enabled during the instruction. A wrong write-enable latch or protect field is visible at the next status read, which takes about two byte times. A broken page pointer or commit sequencer only shows when the data is read back after the busy window, so each write is followed by a full readback compared against a model of the array. Busy length is checked from both sides: the flag must still be set shortly before the window ends and must be clear shortly after it.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [2:0] OP_LO_READ = 3'b011;
  localparam logic [2:0] OP_LO_WRITE = 3'b010;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_STAT, ST_SRDATA, ST_TAIL, ST_SKIP
  } fe_state_t;

  typedef enum logic [1:0] {
    TAIL_NONE, TAIL_WEN_SET, TAIL_WEN_CLR, TAIL_STAT_WR
  } tail_t;

  function automatic logic page_locked(input logic [1:0] prot, input logic [1:0] top2);
    case (prot)
      2'b00:   page_locked = 1'b0;
      2'b01:   page_locked = (top2 == 2'b11);
      2'b10:   page_locked = top2[1];
      default: page_locked = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_rise,
  output logic si_s,
  output logic hold_act
);
  // bit order {hold_n, cs_n, si, sck}
  localparam logic [3:0] IDLE = 4'b1100;

  logic [3:0] pipe [STAGES];
  logic [1:0] prev; // {cs_n, sck}
  logic [3:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= IDLE;
      prev <= 2'b10;
    end else begin
      pipe[0] <= {hold_n, cs_n, si, sck};
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= {pipe[STAGES-1][2], pipe[STAGES-1][0]};
    end
  end

  assign cur       = pipe[STAGES-1];
  assign sck_rise  = cur[0] & ~prev[0];
  assign sck_fall  = ~cur[0] & prev[0];
  assign cs_active = ~cur[2];
  assign cs_rise   = cur[2] & ~prev[1];
  assign si_s      = cur[1];
  assign hold_act  = ~cur[3];
endmodule

// File: rtl/spi_page_buffer.sv
module spi_page_buffer #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_full;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear)
        slot_full[i] <= 1'b0;
      else if (wr_en && wr_idx == PAGE_W'(i))
        slot_full[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == PAGE_W'(i))
        slot_data[i] <= wr_data;
    end
  end

  assign rd_data   = slot_data[rd_idx];
  assign rd_valid  = slot_full[rd_idx];
  assign any_valid = |slot_full;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
  import eeprom_spi_pkg::*;
#(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  input  logic spi_hold_n,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BANK_W     = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  // pin front end
  logic sck_rise, sck_fall, cs_active, cs_rise, si_s, hold_act;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .hold_n(spi_hold_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_active(cs_active), .cs_rise(cs_rise), .si_s(si_s), .hold_act(hold_act)
  );

  fe_state_t          state;
  tail_t              tail;
  logic [6:0]         rx_sh;
  logic [2:0]         bit_cnt;
  logic [2:0]         out_cnt;
  logic [7:0]         tx_sh;
  logic [ADDR_W-1:0]  cur_addr;
  logic               a8;
  logic               is_read;
  logic [BANK_W-1:0]  page_idx;
  logic [PAGE_W-1:0]  wr_ptr;
  logic [1:0]         sr_bp;
  logic               wel;
  logic [1:0]         bp;
  logic               busy;
  logic [CNT_W-1:0]   busy_cnt;
  logic               drive;

  logic               rise_ev, fall_ev, byte_done, out_state;
  logic [7:0]         rx_byte, status_byte, first_byte;
  logic [ADDR_W-1:0]  addr_full;
  logic               pb_clear, pb_we, pb_valid, pb_any;
  logic [7:0]         pb_rdata;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr;
  logic [7:0]         mem_q;
  logic               locked;

  assign rise_ev     = sck_rise && cs_active && !hold_act;
  assign fall_ev     = sck_fall && cs_active && !hold_act;
  assign byte_done   = rise_ev && (bit_cnt == 3'd7);
  assign rx_byte     = {rx_sh, si_s};
  assign addr_full   = {a8, rx_byte};
  assign out_state   = (state == ST_RDATA) || (state == ST_STAT);
  assign status_byte = {4'b0000, bp, wel, busy};
  assign first_byte  = (state == ST_STAT) ? status_byte : mem_q;
  assign locked      = page_locked(bp, page_idx[BANK_W-1 -: 2]);

  assign pb_clear  = byte_done && (state == ST_ADDR) && !is_read;
  assign pb_we     = byte_done && (state == ST_WDATA);
  assign mem_we    = busy && (busy_cnt < CNT_W'(PAGE_BYTES)) && pb_valid;
  assign mem_waddr = {page_idx, busy_cnt[PAGE_W-1:0]};

  spi_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_page (
    .clk(clk), .rst(rst), .clear(pb_clear), .wr_en(pb_we), .wr_idx(wr_ptr),
    .wr_data(rx_byte), .rd_idx(busy_cnt[PAGE_W-1:0]), .rd_data(pb_rdata),
    .rd_valid(pb_valid), .any_valid(pb_any)
  );

  spi_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pb_rdata),
    .raddr(cur_addr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CMD;
      tail      <= TAIL_NONE;
      rx_sh     <= '0;
      bit_cnt   <= '0;
      out_cnt   <= '0;
      tx_sh     <= '0;
      cur_addr  <= '0;
      a8        <= 1'b0;
      is_read   <= 1'b0;
      page_idx  <= '0;
      wr_ptr    <= '0;
      sr_bp     <= '0;
      wel       <= 1'b0;
      bp        <= '0;
      busy      <= 1'b0;
      busy_cnt  <= '0;
      drive     <= 1'b0;
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
    end else begin
      spi_so_oe <= drive && cs_active && !hold_act;

      // self-timed commit window
      if (busy) begin
        if (busy_cnt == CNT_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
        else busy_cnt <= busy_cnt + CNT_W'(1);
      end

      if (!cs_active) begin
        state   <= ST_CMD;
        bit_cnt <= '0;
        out_cnt <= '0;
        drive   <= 1'b0;
      end

      // actions taken when the host deselects
      if (cs_rise) begin
        if (state == ST_TAIL) begin
          case (tail)
            TAIL_WEN_SET: wel <= 1'b1;
            TAIL_WEN_CLR: wel <= 1'b0;
            TAIL_STAT_WR: if (wel) begin
              bp  <= sr_bp;
              wel <= 1'b0;
            end
            default: ;
          endcase
        end
        if (state == ST_WDATA && bit_cnt == 3'd0 && pb_any && wel && !busy && !locked) begin
          busy     <= 1'b1;
          busy_cnt <= '0;
          wel      <= 1'b0;
        end
      end

      // input bits on rising SCK
      if (rise_ev) begin
        rx_sh   <= {rx_sh[5:0], si_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (state == ST_TAIL) begin
          state <= ST_SKIP;
        end else if (bit_cnt == 3'd7) begin
          case (state)
            ST_CMD: begin
              if (busy) begin
                state <= (rx_byte == OP_STAT_RD) ? ST_STAT : ST_SKIP;
              end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OP_LO_READ) begin
                a8      <= rx_byte[3];
                is_read <= 1'b1;
                state   <= ST_ADDR;
              end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OP_LO_WRITE) begin
                a8      <= rx_byte[3];
                is_read <= 1'b0;
                state   <= wel ? ST_ADDR : ST_SKIP;
              end else begin
                case (rx_byte)
                  OP_WEN_SET: begin tail <= TAIL_WEN_SET; state <= ST_TAIL; end
                  OP_WEN_CLR: begin tail <= TAIL_WEN_CLR; state <= ST_TAIL; end
                  OP_STAT_RD: state <= ST_STAT;
                  OP_STAT_WR: state <= wel ? ST_SRDATA : ST_SKIP;
                  default:    state <= ST_SKIP;
                endcase
              end
            end
            ST_ADDR: begin
              if (is_read) begin
                cur_addr <= addr_full;
                state    <= ST_RDATA;
              end else begin
                page_idx <= addr_full[ADDR_W-1:PAGE_W];
                wr_ptr   <= addr_full[PAGE_W-1:0];
                state    <= ST_WDATA;
              end
            end
            ST_WDATA: wr_ptr <= wr_ptr + PAGE_W'(1);
            ST_SRDATA: begin
              sr_bp <= rx_byte[3:2];
              tail  <= TAIL_STAT_WR;
              state <= ST_TAIL;
            end
            default: ;
          endcase
        end
      end

      // output bits on falling SCK
      if (fall_ev && out_state) begin
        drive   <= 1'b1;
        out_cnt <= out_cnt + 3'd1;
        if (out_cnt == 3'd0) begin
          spi_so <= first_byte[7];
          tx_sh  <= {first_byte[6:0], 1'b0};
        end else begin
          spi_so <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (out_cnt == 3'd7 && state == ST_RDATA) cur_addr <= cur_addr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/eeprom_spi_checker.sv
module eeprom_spi_checker #(
  parameter int WRITE_CYCLES = 2000
) (
  input logic clk,
  input logic rst,
  input logic cs_rise,
  input logic hold_act,
  input logic so_oe,
  input logic out_state,
  input logic busy,
  input logic wel,
  input logic mem_we
);
  localparam int RUN_W = $clog2(WRITE_CYCLES + 2);
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else busy_run <= busy_run + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      p_busy_window_r7: assert (busy_run <= RUN_W'(WRITE_CYCLES))
        else $error("busy window longer than WRITE_CYCLES");
    end
  end

  p_quiet_outside_data_r11: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> out_state);

  p_hold_floats_r10: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(!hold_act));

  p_array_write_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_commit_on_deselect_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise));

  p_latch_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);

  p_latch_set_on_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_rise));
endmodule

bind eeprom_spi_slave eeprom_spi_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_rise(cs_rise), .hold_act(hold_act),
  .so_oe(spi_so_oe), .out_state(out_state), .busy(busy), .wel(wel),
  .mem_we(mem_we)
);

// File: tb/eeprom_spi_slave_test.sv
module eeprom_spi_slave_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  bit done = 1'b0;
  logic [7:0] ref_mem [512];

  always #10 clk = ~clk;

  eeprom_spi_slave uut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input bit b, output bit r, output bit oe);
    if (mode3) begin
      sck = 1'b0; si = b; wclk(HALF);
      r = so; oe = so_oe; sck = 1'b1; wclk(HALF);
    end else begin
      si = b; wclk(HALF);
      r = so; oe = so_oe; sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_any);
    bit r, oe;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r, oe);
      rx[i] = r;
      oe_any |= oe;
    end
  endtask

  task automatic sel();
    sck = mode3; wclk(2); cs_n = 1'b0; wclk(6);
  endtask

  task automatic desel();
    wclk(6); cs_n = 1'b1; wclk(10);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d; bit oe;
    sel(); spi_byte(op, d, oe); desel();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] d; bit oe;
    sel(); spi_byte(8'h05, d, oe); spi_byte(8'h00, s, oe); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      read_status(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic write_bytes(input logic [8:0] addr, input int n, input logic [7:0] seed,
                             input bit commit);
    logic [7:0] d; bit oe;
    sel();
    spi_byte({4'h0, addr[8], 3'b010}, d, oe);
    spi_byte(addr[7:0], d, oe);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      logic [3:0] lo;
      v = seed ^ 8'(i * 37);
      lo = addr[3:0] + 4'(i);
      spi_byte(v, d, oe);
      if (commit) ref_mem[{addr[8:4], lo}] = v;
    end
    desel();
  endtask

  task automatic read_check(input logic [8:0] addr, input int n, input string req);
    logic [7:0] d; bit oe;
    sel();
    spi_byte({4'h0, addr[8], 3'b011}, d, oe);
    spi_byte(addr[7:0], d, oe);
    for (int i = 0; i < n; i++) begin
      logic [8:0] a;
      a = addr + 9'(i);
      spi_byte(8'h00, d, oe);
      check(d == ref_mem[a], req, $sformatf("read @%0h", a), d, ref_mem[a]);
    end
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check(so_oe == 1'b0, "R1", "so_oe after reset", so_oe, 0);
    read_status(s);
    check(s == 8'h00, "R1", "status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s, d; bit oe, r;
    cmd1(8'h06); read_status(s);
    check(s == 8'h02, "R2", "status after set", s, 8'h02);
    cmd1(8'h04); read_status(s);
    check(s == 8'h00, "R2", "status after clear", s, 8'h00);
    sel(); spi_byte(8'h06, d, oe); spi_bit(1'b0, r, oe); desel();
    read_status(s);
    check(s == 8'h00, "R2", "set with extra bit", s, 8'h00);
  endtask

  task automatic prefill();
    logic [8:0] pages [6] = '{9'h0A0, 9'h180, 9'h1F0, 9'h000, 9'h100, 9'h170};
    logic [7:0] s;
    for (int p = 0; p < 6; p++) begin
      cmd1(8'h06);
      write_bytes(pages[p], 16, 8'(8'h11 * (p + 1)), 1'b1);
      wait_ready();
      read_status(s);
      check(s == 8'h00, "R8", "latch after commit", s, 8'h00);
      read_check(pages[p], 16, "R5");
    end
  endtask

  task automatic t_page_wrap();
    cmd1(8'h06);
    write_bytes(9'h1F8, 12, 8'hC3, 1'b1);
    wait_ready();
    read_check(9'h1F0, 16, "R5");
  endtask

  task automatic t_read_wrap();
    read_check(9'h1FE, 4, "R4");
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    mode3 = 1'b1;
    read_check(9'h0A3, 5, "R3");
    cmd1(8'h06); read_status(s);
    check(s == 8'h02, "R3", "mode 3 status", s, 8'h02);
    cmd1(8'h04);
    mode3 = 1'b0;
    sck = 1'b0; wclk(4);
  endtask

  task automatic t_discard();
    logic [7:0] s, d; bit oe, r;
    cmd1(8'h06);
    sel(); spi_byte(8'h02, d, oe); spi_byte(8'hA0, d, oe); spi_byte(8'h5A, d, oe);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, r, oe);
    desel();
    read_status(s);
    check(s == 8'h02, "R6", "partial byte status", s, 8'h02);
    sel(); spi_byte(8'h02, d, oe); spi_byte(8'hA0, d, oe); desel();
    read_status(s);
    check(s == 8'h02, "R6", "no data status", s, 8'h02);
    cmd1(8'h04);
    write_bytes(9'h0A0, 2, 8'hEE, 1'b0);
    read_status(s);
    check(s == 8'h00, "R6", "no latch status", s, 8'h00);
    read_check(9'h0A0, 3, "R6");
  endtask

  task automatic t_busy();
    logic [7:0] s, d; bit oe, oe_any;
    cmd1(8'h06);
    write_bytes(9'h040, 2, 8'h3C, 1'b1);
    read_status(s);
    check(s == 8'h01, "R7", "status during busy", s, 8'h01);
    check(s[1] == 1'b0, "R8", "latch during busy", s[1], 0);
    sel();
    spi_byte(8'h03, d, oe); spi_byte(8'h40, d, oe);
    spi_byte(8'h00, d, oe_any);
    desel();
    check(oe_any == 1'b0, "R7", "SO driven for read in busy", oe_any, 0);
    cmd1(8'h06);
    wait_ready();
    read_status(s);
    check(s == 8'h00, "R7", "set ignored in busy", s, 8'h00);
    read_check(9'h040, 2, "R7");
    cmd1(8'h06);
    write_bytes(9'h048, 1, 8'h77, 1'b1);
    wclk(1500); read_status(s);
    check(s[0] == 1'b1, "R7", "busy before window end", s[0], 1);
    wclk(400); read_status(s);
    check(s[0] == 1'b0, "R7", "busy after window end", s[0], 0);
  endtask

  task automatic stat_wr(input logic [7:0] v);
    logic [7:0] d; bit oe;
    sel(); spi_byte(8'h01, d, oe); spi_byte(v, d, oe); desel();
  endtask

  task automatic t_protect();
    logic [7:0] s;
    stat_wr(8'h0C); read_status(s);
    check(s == 8'h00, "R9", "status write without latch", s, 8'h00);
    cmd1(8'h06); stat_wr(8'h04); read_status(s);
    check(s == 8'h04, "R9", "quarter protect", s, 8'h04);
    cmd1(8'h06);
    write_bytes(9'h180, 2, 8'h99, 1'b0);
    read_status(s);
    check(s == 8'h06, "R9", "locked write status", s, 8'h06);
    read_check(9'h180, 2, "R9");
    write_bytes(9'h170, 2, 8'h42, 1'b1);
    wait_ready();
    read_check(9'h170, 2, "R9");
    cmd1(8'h06); stat_wr(8'h08);
    cmd1(8'h06);
    write_bytes(9'h100, 1, 8'h24, 1'b0);
    read_status(s);
    check(s == 8'h0A, "R9", "half protect status", s, 8'h0A);
    read_check(9'h100, 1, "R9");
    stat_wr(8'h00); read_status(s);
    check(s == 8'h00, "R9", "protect cleared", s, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d, got; bit oe, r;
    sel();
    spi_byte(8'h03, d, oe); spi_byte(8'hA5, d, oe);
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, r, oe); got[i] = r; end
    wclk(4); hold_n = 1'b0; wclk(HALF);
    check(so_oe == 1'b0, "R10", "SO during hold", so_oe, 0);
    si = 1'b1;
    for (int k = 0; k < 3; k++) begin sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF); end
    hold_n = 1'b1; wclk(HALF + 2);
    check(so_oe == 1'b1, "R10", "SO after hold", so_oe, 1);
    for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, r, oe); got[i] = r; end
    check(got == ref_mem[9'h0A5], "R10", "byte across hold", got, ref_mem[9'h0A5]);
    spi_byte(8'h00, d, oe);
    check(d == ref_mem[9'h0A6], "R10", "next byte after hold", d, ref_mem[9'h0A6]);
    desel();
  endtask

  task automatic t_quiet();
    logic [7:0] d; bit oe_cmd, oe_dat;
    sel(); spi_byte(8'h05, d, oe_cmd); spi_byte(8'h00, d, oe_dat); desel();
    check(oe_cmd == 1'b0, "R11", "SO during instruction", oe_cmd, 0);
    check(oe_dat == 1'b1, "R11", "SO during status data", oe_dat, 1);
    check(so_oe == 1'b0, "R11", "SO when deselected", so_oe, 0);
  endtask

  initial begin
    wclk(5); rst = 1'b0; wclk(10);
    t_reset();
    t_latch();
    prefill();
    t_page_wrap();
    t_read_wrap();
    t_mode3();
    t_discard();
    t_busy();
    t_protect();
    t_hold();
    t_quiet();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule